// File: doc/BRIEF.md
# DRAM Access Timing Sequencer

This block drives the strobe and address timing for a single asynchronous DRAM bank. A requester presents a row, a column and a direction flag on `reqValid`, or asks for a refresh on `refReq`. The sequencer then steps through a row phase, an optional column set-up phase, a CAS pulse and a precharge interval. It drives active-low `rasN` and `casN`, a multiplexed address bus and a `colSel` flag that marks when the column is on the bus. `ready` is high only while the sequencer is idle and able to take a new request. `done` pulses in the final cycle of each CAS strobe.

A set of static configuration pins sets the timing:

- the precharge length,
- whether the row address is held for an extra cycle before CAS,
- the CAS pulse width for each direction,
- an extra idle cycle after refresh,
- an interleave flag that forces the shortest CAS pulse.

A refresh uses the CAS-before-RAS form. When a refresh and an access are requested together, the refresh wins.

Top module: `dram_timing_seq`

## Requirements
- R1: Out of reset `rasN` and `casN` are high, `colSel` is low and `ready` is high.
- R2: After each access or refresh, `rasN` and `casN` stay high for a precharge interval before `ready` returns. The interval is 1 cycle when `cfgPreExt` is 0 and 2 cycles when it is 1.
- R3: On an access, `colSel` goes to 1 (column on `addr`) exactly one cycle after `rasN` falls. Before that cycle `addr` carries the row.
- R4: With `cfgRah` = 0, `casN` falls one cycle after `rasN` falls. With `cfgRah` = 1, one extra column set-up cycle keeps `casN` high, so `casN` falls two cycles after `rasN`.
- R5: CAS width code `cfgCasW` (2 bits): code 2'b10 gives a 2-cycle `casN` pulse on reads (`reqWrite` = 0) and a 1-cycle pulse on writes. Codes 2'b00, 2'b01 and the reserved 2'b11 give a 1-cycle pulse in both directions.
- R6: When `cfgInterleave` is 1, `cfgCasW` has no effect and every `casN` pulse is 1 cycle wide.
- R7: A refresh drives `casN` low one cycle before `rasN`, keeps both low together for one cycle, and then raises both.
- R8: When `cfgRefExt` is 1, one extra cycle with both strobes high is added after a refresh, ahead of the precharge interval.
- R9: Requests are taken only while `ready` is high. A request presented while busy is ignored and does not change the sequence in progress.
- R10: When `refReq` and `reqValid` are high together while idle, a refresh is performed.
- R11: `done` is high for exactly one cycle per operation: in the last `casN`-low cycle of an access, and in the cycle where both strobes are low during a refresh.
- R12: The row and column are captured when the request is taken, so `addr` shows those values throughout the access, whatever the request inputs do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ADDR_W | Row address |
| reqCol | input | ADDR_W | Column address |
| refReq | input | 1 | Refresh request |
| cfgPreExt | input | 1 | 2-cycle precharge when 1 |
| cfgRah | input | 1 | Extra row-hold/column set-up cycle when 1 |
| cfgCasW | input | 2 | CAS width code |
| cfgRefExt | input | 1 | Extra idle cycle after refresh when 1 |
| cfgInterleave | input | 1 | Interleaved mode; forces 1-cycle CAS |
| ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Last CAS cycle of the operation |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| colSel | output | 1 | 1 = column on `addr`, 0 = row |
| addr | output | ADDR_W | Multiplexed DRAM address |

## Verification
The assertions assume that the configuration pins hold steady from the moment a request is taken until `ready` returns. They also assume that refresh and access requests are single-cycle pulses that the requester raises only while `ready` is high, apart from the deliberate busy-time pokes. The bench changes configuration only in idle cycles. It sweeps every combination of precharge, row-hold, CAS code, interleave and direction for accesses, and every refresh option. It also tests the priority case and requests made while busy, and computes each cycle's expected strobe pattern from the configured cycle counts.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COLSU, ST_CAS, ST_REFC, ST_REFB, ST_REFX, ST_PRE
  } seqState_t;

  typedef struct packed {
    logic load;
    logic rasOn;
    logic casOn;
    logic colSel;
  } strobe_t;

  localparam logic [1:0] CAS_RD2 = 2'b10;
endpackage

// File: rtl/dts_ctrl.sv
module dts_ctrl
  import dts_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       refReq,
  input  logic       cfgPreExt,
  input  logic       cfgRah,
  input  logic [1:0] cfgCasW,
  input  logic       cfgRefExt,
  input  logic       cfgInterleave,
  output strobe_t    strb,
  output logic       ready,
  output logic       done
);
  seqState_t st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic isWr, isWrNxt;
  logic casLong;
  logic [CNT_W-1:0] casLoad, preLoad;

  // Long CAS only for reads with code 10 outside interleaved mode
  assign casLong = !cfgInterleave && (cfgCasW == CAS_RD2) && !isWr;
  assign casLoad = CNT_W'(casLong);
  assign preLoad = CNT_W'(cfgPreExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      isWr <= 1'b0;
    end else begin
      st   <= stNxt;
      cnt  <= cntNxt;
      isWr <= isWrNxt;
    end
  end

  always_comb begin
    stNxt   = st;
    cntNxt  = cnt;
    isWrNxt = isWr;
    case (st)
      ST_IDLE: begin
        if (refReq) stNxt = ST_REFC;
        else if (reqValid) begin
          stNxt   = ST_ROW;
          isWrNxt = reqWrite;
        end
      end
      ST_ROW: begin
        if (cfgRah) stNxt = ST_COLSU;
        else begin
          stNxt  = ST_CAS;
          cntNxt = casLoad;
        end
      end
      ST_COLSU: begin
        stNxt  = ST_CAS;
        cntNxt = casLoad;
      end
      ST_CAS: begin
        if (cnt == '0) begin
          stNxt  = ST_PRE;
          cntNxt = preLoad;
        end else cntNxt = cnt - 1'b1;
      end
      ST_REFC: stNxt = ST_REFB;
      ST_REFB: begin
        if (cfgRefExt) stNxt = ST_REFX;
        else begin
          stNxt  = ST_PRE;
          cntNxt = preLoad;
        end
      end
      ST_REFX: begin
        stNxt  = ST_PRE;
        cntNxt = preLoad;
      end
      ST_PRE: begin
        if (cnt == '0) stNxt = ST_IDLE;
        else cntNxt = cnt - 1'b1;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.load   = (st == ST_IDLE) && !refReq && reqValid;
    strb.rasOn  = (st == ST_ROW) || (st == ST_COLSU) || (st == ST_CAS) || (st == ST_REFB);
    strb.casOn  = (st == ST_CAS) || (st == ST_REFC) || (st == ST_REFB);
    strb.colSel = (st == ST_COLSU) || (st == ST_CAS);
  end

  assign ready = (st == ST_IDLE);
  assign done  = ((st == ST_CAS) && (cnt == '0)) || (st == ST_REFB);

  AST_PRE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PRE && !cfgPreExt) |=> ready);  // R2
  AST_PRE_LONG: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PRE && $past(st) != ST_PRE && cfgPreExt) |=> !ready);  // R2
  AST_CAS_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CAS && (cfgCasW != CAS_RD2 || isWr)) |=> st == ST_PRE);  // R5
  AST_IL_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CAS && cfgInterleave) |=> st == ST_PRE);  // R6
  AST_REF_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REFB && cfgRefExt) |=> (st == ST_REFX && !strb.rasOn && !strb.casOn));  // R8
  AST_BUSY_NOLOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !strb.load);  // R9
endmodule

// File: rtl/dts_dpath.sv
module dts_dpath
  import dts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  output logic              rasN,
  output logic              casN,
  output logic              colSel,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] rowQ, colQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (strb.load) begin
      rowQ <= reqRow;
      colQ <= reqCol;
    end
  end

  assign rasN   = ~strb.rasOn;
  assign casN   = ~strb.casOn;
  assign colSel = strb.colSel;
  assign addr   = strb.colSel ? colQ : rowQ;

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && rasN) |=> (!rasN && !casN));  // R7
  AST_CBR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && !casN && $past(rasN) && $past(!casN)) |=> (rasN && casN));  // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (colSel && $past(colSel)) |-> $stable(addr));  // R12
endmodule

// File: rtl/dram_timing_seq.sv
module dram_timing_seq
  import dts_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqRow,
  input  logic [ADDR_W-1:0] reqCol,
  input  logic              refReq,
  input  logic              cfgPreExt,
  input  logic              cfgRah,
  input  logic [1:0]        cfgCasW,
  input  logic              cfgRefExt,
  input  logic              cfgInterleave,
  output logic              ready,
  output logic              done,
  output logic              rasN,
  output logic              casN,
  output logic              colSel,
  output logic [ADDR_W-1:0] addr
);
  strobe_t strb;

  dts_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .refReq(refReq), .cfgPreExt(cfgPreExt), .cfgRah(cfgRah),
    .cfgCasW(cfgCasW), .cfgRefExt(cfgRefExt), .cfgInterleave(cfgInterleave),
    .strb(strb), .ready(ready), .done(done)
  );

  dts_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqRow(reqRow), .reqCol(reqCol),
    .rasN(rasN), .casN(casN), .colSel(colSel), .addr(addr)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (rasN && casN && !colSel));  // R1
  AST_COL_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && casN) |=> colSel);  // R3
  AST_CAS_NORAH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && casN && !cfgRah) |=> !casN);  // R4
  AST_CAS_RAH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && casN && cfgRah) |=> casN);  // R4
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ready && refReq) |=> (!casN && rasN));  // R10
  AST_DONE_CAS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !casN);  // R11
endmodule

// File: tb/tb_dram_timing_seq.sv
module tb_dram_timing_seq;
  localparam int AW = 10;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, refReq = 0;
  logic [AW-1:0] reqRow = '0, reqCol = '0;
  logic cfgPreExt = 0, cfgRah = 0, cfgRefExt = 0, cfgInterleave = 0;
  logic [1:0] cfgCasW = 2'b00;
  logic ready, done, rasN, casN, colSel;
  logic [AW-1:0] addr;
  int nChk = 0, nFail = 0, cyc = 0;

  always #5 clk = ~clk;

  dram_timing_seq #(.ADDR_W(AW), .CNT_W(2)) dut (.*);

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sig(logic r, logic c, logic s, logic rd, logic d);
    return {27'd0, r, c, s, rd, d};
  endfunction

  task automatic runAccess(input logic pe, input logic rah, input logic [1:0] cw,
                           input logic il, input logic wr, input logic [AW-1:0] row,
                           input logic [AW-1:0] col, input logic poke, input string req);
    int casLen, preLen, total;
    casLen = (!il && cw == 2'b10 && !wr) ? 2 : 1;
    preLen = pe ? 2 : 1;
    total  = 1 + int'(rah) + casLen + preLen;
    @(negedge clk);
    cfgPreExt = pe; cfgRah = rah; cfgCasW = cw; cfgInterleave = il;
    reqValid = 1; reqWrite = wr; reqRow = row; reqCol = col;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      reqValid = 0; reqRow = ~row; reqCol = ~col; refReq = 0;
      if (k == 0) begin  // R3 R4: row phase
        chk(req, sig(rasN, casN, colSel, ready, done), sig(0, 1, 0, 0, 0));
        chk("R12", addr, row);
      end else if (rah && k == 1) begin  // R4: column set-up
        chk(req, sig(rasN, casN, colSel, ready, done), sig(0, 1, 1, 0, 0));
        chk("R12", addr, col);
      end else if (k < 1 + int'(rah) + casLen) begin  // R5 R6 R11
        chk(req, sig(rasN, casN, colSel, ready, done),
            sig(0, 0, 1, 0, (k == int'(rah) + casLen) ? 1'b1 : 1'b0));
        chk("R12", addr, col);
      end else if (k < total) begin  // R2 precharge
        chk(req, sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 0, 0));
      end else begin
        chk("R2", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 1, 0));
      end
      if (poke && k == 0) begin  // R9: requests while busy
        reqValid = 1; refReq = 1; reqWrite = ~wr;
      end
    end
  endtask

  task automatic runRefresh(input logic pe, input logic ext, input logic withAcc);
    int preLen, total;
    preLen = pe ? 2 : 1;
    total  = 2 + int'(ext) + preLen;
    @(negedge clk);
    cfgPreExt = pe; cfgRefExt = ext;
    refReq = 1; reqValid = withAcc;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      refReq = 0; reqValid = 0;
      if (k == 0)
        chk(withAcc ? "R10" : "R7", sig(rasN, casN, colSel, ready, done), sig(1, 0, 0, 0, 0));
      else if (k == 1)
        chk("R7", sig(rasN, casN, colSel, ready, done), sig(0, 0, 0, 0, 1));
      else if (k < total)
        chk(ext ? "R8" : "R2", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 0, 0));
      else
        chk("R8", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 1, 0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 1, 0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 1, 0));
    for (int pe = 0; pe < 2; pe++)
      for (int rah = 0; rah < 2; rah++)
        for (int cw = 0; cw < 4; cw++)
          for (int il = 0; il < 2; il++)
            for (int wr = 0; wr < 2; wr++)
              runAccess(pe[0], rah[0], cw[1:0], il[0], wr[0],
                        AW'(pe * 97 + rah * 33 + cw * 5 + il * 2 + wr + 1),
                        AW'(600 + cw * 40 + il * 11 + wr * 3 + pe),
                        1'b0, il ? "R6" : "R5");
    for (int pe = 0; pe < 2; pe++)
      for (int ext = 0; ext < 2; ext++)
        runRefresh(pe[0], ext[0], 1'b0);
    runRefresh(1'b0, 1'b0, 1'b1);  // R10 priority
    runAccess(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 10'h155, 10'h2aa, 1'b1, "R9");
    repeat (2) begin  // R9: the busy-time pokes left no pending operation
      @(negedge clk);
      chk("R9", sig(rasN, casN, colSel, ready, done), sig(1, 1, 0, 1, 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule